// File: doc/BRIEF.md
# Receive Filter Indirect Memory Port

This block holds the storage used by an Ethernet receive address filter: a six-byte station address for exact matching and a 256-byte hash table. A host reaches both through two registers on a simple synchronous register bus. The control register carries a filter address field and the accept-mode enable bits. The data register moves one 16-bit word at the address currently held in the control register. Byte pairs are packed with the lower-indexed byte in the low half of the word.

An address that names no word, or names a hash-table word at an odd offset, is not fatal. The block sets a sticky error flag. A read of such an address returns zero, and a write to it changes nothing. A control write that asks for unicast hashing is also refused with the error flag. The station address is driven out continuously for the match logic, and so are the six accept-mode bits.

Top module: `rxf_port`

## Requirements
- R1: After reset, the control register reads 0, `err` is 0, `accept` is 0, `station` is 0, and every station-address word and hash-table word reads 0.
- R2: A data write while the filter address is 0x000, 0x002 or 0x004 stores `wdata[7:0]` as station byte 2k and `wdata[15:8]` as byte 2k+1, for the word k = address/2. `station` carries byte n in bits 8n+7:8n, and the update is visible one cycle after the write.
- R3: A data read at 0x000, 0x002 or 0x004 returns the word {byte 2k+1, byte 2k} in `rdata[15:0]`, with bits 31:16 zero.
- R4: Even filter addresses 0x100 to 0x1FE each name a distinct hash-table word holding bytes (a-0x100) and (a-0x100+1), packed as in R2. The word can be written and read back through the data register.
- R5: A data access at an odd address in the range 0x100 to 0x1FF sets `err`. A read returns 0, and a write leaves every hash word unchanged.
- R6: A data access at any address that is not 0x000, 0x002, 0x004 or an even address from 0x100 to 0x1FE sets `err`. The station addresses 0x001, 0x003 and 0x005 count as such addresses. A read returns 0, and a write leaves the storage unchanged.
- R7: A control write with bit 22 (unicast hash request) set sets `err` and is ignored as a whole: the filter address and the accept bits keep their previous values.
- R8: The control register has this layout: bits 8:0 hold the filter address, and bits 21:16 hold the accept bits {mcast-hash, arp, perfect, all-unicast, all-multicast, broadcast}, with broadcast at bit 16. Every other bit reads as 0. `accept` mirrors bits 21:16, so the multicast-hash enable appears on `accept[5]`.
- R9: `err` stays set until reset, and valid accesses keep working while it is set.
- R10: A data access does not change the filter address, so back-to-back data reads return the same word.
- R11: `rvalid` is high exactly one cycle after each cycle with `rd_en` high, and `rdata` is valid in that cycle. Register select 0 is the control register and 1 is the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| err | output | 1 | Sticky access error flag |
| accept | output | 6 | Accept-mode enable bits |
| station | output | 48 | Station address, byte n in bits 8n+7:8n |

## Verification
The hardest cases to show from the ports are the ignored writes. A refused write leaves no trace on its own, so the bench must first plant known values next to the target and then read them back after the bad access. It writes hash words on both sides of an odd address and then writes through the odd address. It also fills the station address before writing to an out-of-range address. Because `err` is sticky, each error class runs after a fresh reset, so that the flag's rise can be tied to one cause.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int BUS_W         = 32;
    localparam int WORD_W        = 16;
    localparam int FADDR_W       = 9;
    localparam int STA_BYTES     = 6;
    localparam int HASH_BASE     = 256;
    localparam int HASH_BYTES    = 256;
    localparam int HASH_WORDS    = HASH_BYTES / 2;
    localparam int STA_WORDS     = STA_BYTES / 2;
    localparam int IDX_W         = $clog2(HASH_WORDS);
    localparam int ACC_N         = 6;
    localparam int CTRL_ACC_LSB  = 16;
    localparam int CTRL_UHASH    = 22;

    typedef enum logic [1:0] {
        TGT_STA,
        TGT_HASH,
        TGT_BAD
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] widx;
    } fdec_t;

    typedef struct packed {
        logic [ACC_N-1:0]   acc;
        logic [FADDR_W-1:0] faddr;
    } ctrl_t;

    typedef enum logic {
        SRC_REG,
        SRC_HASH
    } rsrc_e;

    function automatic logic [BUS_W-1:0] ctrl_to_bus(ctrl_t c);
        logic [BUS_W-1:0] r;
        r = '0;
        r[FADDR_W-1:0] = c.faddr;
        r[CTRL_ACC_LSB +: ACC_N] = c.acc;
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] zext_word(logic [WORD_W-1:0] w);
        return {{(BUS_W-WORD_W){1'b0}}, w};
    endfunction

endpackage

// File: rtl/rxf_decode.sv
module rxf_decode
    import rxf_pkg::*;
#(
    parameter int P_STA_BYTES  = STA_BYTES,
    parameter int P_HASH_BASE  = HASH_BASE,
    parameter int P_HASH_BYTES = HASH_BYTES
) (
    input  logic [FADDR_W-1:0] faddr,
    output fdec_t              dec
);
    localparam int HASH_LIM = P_HASH_BASE + P_HASH_BYTES;

    logic [FADDR_W-1:0] hoff;

    always_comb begin
        hoff     = faddr - FADDR_W'(P_HASH_BASE);
        dec.tgt  = TGT_BAD;
        dec.widx = '0;
        if (!faddr[0]) begin
            if (int'(faddr) < P_STA_BYTES) begin
                dec.tgt  = TGT_STA;
                dec.widx = faddr[IDX_W:1];
            end else if (int'(faddr) >= P_HASH_BASE && int'(faddr) < HASH_LIM) begin
                dec.tgt  = TGT_HASH;
                dec.widx = hoff[IDX_W:1];
            end
        end
    end
endmodule

// File: rtl/rxf_station_regs.sv
module rxf_station_regs
    import rxf_pkg::*;
#(
    parameter int WORDS = STA_WORDS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORDS*WORD_W-1:0] station
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                word_q <= wdata;
            end
        end
        assign station[g*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/rxf_hash_ram.sv
module rxf_hash_ram
    import rxf_pkg::*;
#(
    parameter int WORDS = HASH_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (we) begin
                mem[idx] <= wdata;
            end
            if (re) begin
                rdata <= mem[idx];
            end
        end
    end
endmodule

// File: rtl/rxf_port.sv
module rxf_port
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_sel,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata,
    output logic                 rvalid,
    output logic                 err,
    output logic [ACC_N-1:0]     accept,
    output logic [STA_BYTES*8-1:0] station
);
    ctrl_t             ctrl_q;
    fdec_t             dec;
    logic              ctrl_wr, ctrl_rd, data_wr, data_rd;
    logic              sta_we, hash_we, hash_re, bad_acc, uhash_req;
    logic [WORD_W-1:0] sta_word, hash_rd;
    logic [BUS_W-1:0]  rreg_q;
    rsrc_e             src_q;
    logic              rvalid_q, err_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata[BUS_W-1:CTRL_UHASH+1];

    rxf_decode u_dec (
        .faddr (ctrl_q.faddr),
        .dec   (dec)
    );

    assign ctrl_wr   = wr_en && !reg_sel;
    assign ctrl_rd   = rd_en && !reg_sel;
    assign data_wr   = wr_en && reg_sel;
    assign data_rd   = rd_en && reg_sel;
    assign sta_we    = data_wr && dec.tgt == TGT_STA;
    assign hash_we   = data_wr && dec.tgt == TGT_HASH;
    assign hash_re   = data_rd && dec.tgt == TGT_HASH;
    assign bad_acc   = (data_wr || data_rd) && dec.tgt == TGT_BAD;
    assign uhash_req = ctrl_wr && wdata[CTRL_UHASH];

    rxf_station_regs u_sta (
        .clk     (clk),
        .rst     (rst),
        .we      (sta_we),
        .widx    (dec.widx),
        .wdata   (wdata[WORD_W-1:0]),
        .station (station)
    );

    rxf_hash_ram u_hash (
        .clk   (clk),
        .rst   (rst),
        .we    (hash_we),
        .re    (hash_re),
        .idx   (dec.widx),
        .wdata (wdata[WORD_W-1:0]),
        .rdata (hash_rd)
    );

    always_comb begin
        sta_word = '0;
        for (int i = 0; i < STA_WORDS; i++) begin
            if (dec.widx == IDX_W'(i)) begin
                sta_word = station[i*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            err_q    <= 1'b0;
            rvalid_q <= 1'b0;
            src_q    <= SRC_REG;
            rreg_q   <= '0;
        end else begin
            if (ctrl_wr && !wdata[CTRL_UHASH]) begin
                ctrl_q.faddr <= wdata[FADDR_W-1:0];
                ctrl_q.acc   <= wdata[CTRL_ACC_LSB +: ACC_N];
            end
            err_q    <= err_q | bad_acc | uhash_req;
            rvalid_q <= rd_en;
            src_q    <= hash_re ? SRC_HASH : SRC_REG;
            if (ctrl_rd) begin
                rreg_q <= ctrl_to_bus(ctrl_q);
            end else if (data_rd && dec.tgt == TGT_STA) begin
                rreg_q <= zext_word(sta_word);
            end else begin
                rreg_q <= '0;
            end
        end
    end

    assign rdata  = (src_q == SRC_HASH) ? zext_word(hash_rd) : rreg_q;
    assign rvalid = rvalid_q;
    assign err    = err_q;
    assign accept = ctrl_q.acc;
endmodule

// File: rtl/rxf_port_chk.sv
module rxf_port_chk
    import rxf_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_sel,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [BUS_W-1:0]       wdata,
    input logic [BUS_W-1:0]       rdata,
    input logic                   rvalid,
    input logic                   err,
    input logic [ACC_N-1:0]       accept,
    input logic [STA_BYTES*8-1:0] station,
    input logic [FADDR_W-1:0]     faddr
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!err && accept == '0 && station == '0));

    p_station_low_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel && faddr == '0) |=> station[15:0] == $past(wdata[15:0]));

    p_odd_hash_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel && faddr[0] && faddr[8]) |=> (rdata == '0 && err));

    p_gap_access_err_r6: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && reg_sel && !faddr[8] && faddr[7:0] > 8'd5) |=> err);

    p_uhash_refused_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !reg_sel && wdata[CTRL_UHASH]) |=> (err && accept == $past(accept)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_rvalid_follows_rd_r11: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    p_rvalid_only_after_rd_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid);
endmodule

bind rxf_port rxf_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .rvalid  (rvalid),
    .err     (err),
    .accept  (accept),
    .station (station),
    .faddr   (ctrl_q.faddr)
);

// File: tb/rxf_port_bench.sv
module rxf_port_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        err;
    logic [5:0]  accept;
    logic [47:0] station;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    rxf_port u_rxf_port (
        .clk     (clk),
        .rst     (rst),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .err     (err),
        .accept  (accept),
        .station (station)
    );

    function automatic logic [31:0] ctrl_val(logic [5:0] acc, logic [8:0] fa);
        return {9'd0, 1'b0, acc, 7'd0, fa};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data whenever the design presents a result
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected rvalid actual=%0h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s read actual=%0h expected=%0h", t, rdata, e);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(logic sel, logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic sel, logic [31:0] e, string req);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_addr(logic [8:0] fa);
        bus_write(1'b0, ctrl_val(6'd0, fa));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 err", {63'd0, err}, 64'd0);
        chk("R1 accept", {58'd0, accept}, 64'd0);
        chk("R1 station", {16'd0, station}, 64'd0);
        bus_read(1'b0, 32'd0, "R1 ctrl");
        bus_read(1'b1, 32'd0, "R1 station word");
        set_addr(9'h100);
        bus_read(1'b1, 32'd0, "R1 hash word");

        // R2, R3: station address packing
        set_addr(9'h000);
        bus_write(1'b1, 32'h0000_BBAA);
        chk("R2 word0", {48'd0, station[15:0]}, 64'h0000_BBAA);
        set_addr(9'h002);
        bus_write(1'b1, 32'h0000_DDCC);
        set_addr(9'h004);
        bus_write(1'b1, 32'h0000_FFEE);
        chk("R2 station", {16'd0, station}, 64'h0000_FFEE_DDCC_BBAA);
        set_addr(9'h000);
        bus_read(1'b1, 32'h0000_BBAA, "R3 word0");
        set_addr(9'h002);
        bus_read(1'b1, 32'h0000_DDCC, "R3 word1");
        set_addr(9'h004);
        bus_read(1'b1, 32'h0000_FFEE, "R3 word2");

        // R4: hash table edges and middle; R10: no auto-increment
        set_addr(9'h100); bus_write(1'b1, 32'h0000_1234);
        set_addr(9'h1FE); bus_write(1'b1, 32'h0000_A5C3);
        set_addr(9'h150); bus_write(1'b1, 32'h0000_0F0F);
        set_addr(9'h100); bus_read(1'b1, 32'h0000_1234, "R4 first");
        set_addr(9'h1FE); bus_read(1'b1, 32'h0000_A5C3, "R4 last");
        set_addr(9'h150);
        bus_read(1'b1, 32'h0000_0F0F, "R10 first read");
        bus_read(1'b1, 32'h0000_0F0F, "R10 second read");
        chk("R4 no err", {63'd0, err}, 64'd0);

        // R8: accept bits and control layout
        bus_write(1'b0, ctrl_val(6'b101010, 9'h150));
        chk("R8 accept", {58'd0, accept}, 64'h2A);
        bus_read(1'b0, ctrl_val(6'b101010, 9'h150), "R8 ctrl read");
        bus_write(1'b0, ctrl_val(6'b100000, 9'h000));
        chk("R8 mcast hash", {58'd0, accept}, 64'h20);

        // R7: unicast hash request refused
        bus_write(1'b0, ctrl_val(6'h3F, 9'h004) | 32'h0040_0000);
        chk("R7 err", {63'd0, err}, 64'd1);
        chk("R7 accept kept", {58'd0, accept}, 64'h20);
        bus_read(1'b0, ctrl_val(6'b100000, 9'h000), "R7 ctrl kept");

        // R5: odd hash address
        do_reset();
        chk("R1 err after reset", {63'd0, err}, 64'd0);
        set_addr(9'h150); bus_write(1'b1, 32'h0000_1111);
        set_addr(9'h152); bus_write(1'b1, 32'h0000_2222);
        set_addr(9'h151);
        bus_read(1'b1, 32'd0, "R5 odd read");
        chk("R5 err", {63'd0, err}, 64'd1);
        bus_write(1'b1, 32'h0000_9999);
        set_addr(9'h150); bus_read(1'b1, 32'h0000_1111, "R5 low word kept");
        set_addr(9'h152); bus_read(1'b1, 32'h0000_2222, "R5 high word kept");
        // R9: sticky, valid accesses still work
        bus_write(1'b1, 32'h0000_3333);
        bus_read(1'b1, 32'h0000_3333, "R9 access while err");
        chk("R9 sticky", {63'd0, err}, 64'd1);

        // R6: gap and odd station addresses
        do_reset();
        set_addr(9'h000); bus_write(1'b1, 32'h0000_5A5A);
        set_addr(9'h006);
        bus_read(1'b1, 32'd0, "R6 gap read");
        chk("R6 err", {63'd0, err}, 64'd1);
        bus_write(1'b1, 32'h0000_7777);
        set_addr(9'h001); bus_write(1'b1, 32'h0000_6666);
        bus_read(1'b1, 32'd0, "R6 odd station read");
        set_addr(9'h0FE); bus_read(1'b1, 32'd0, "R6 below hash read");
        chk("R6 station kept", {16'd0, station}, 64'h0000_0000_0000_5A5A);

        // R11: no stray valid, all reads answered
        @(negedge clk);
        chk("R11 rvalid idle", {63'd0, rvalid}, 64'd0);
        chk("R11 queue drained", 64'(exp_q.size()), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule